// File: doc/BRIEF.md
# Secure/Non-Secure Block Access Gate

This block sits on a memory transaction path in front of a protected address range. The range is split into equal power-of-two blocks, and a security table holds one bit per block. Each incoming request carries an address, a non-secure flag, a flag that says its security attribute is unspecified, and a 16-bit master ID. The gate reads the request's block bit and checks it against the request's security world. A request whose world matches goes straight on to the downstream port in the same cycle. A request that does not match is held back.

A request that is held back gets an answer from the gate itself. If the error-response control input is set, that answer is a bus error. If it is clear, a read returns zero, a write is dropped, and the response is OK. The first held-back request also records its address and a packed information word in fault registers and sets a pending flag. The record stays frozen until software asserts the clear input. Programming the table and the control input, and the downstream memory itself, belong to other blocks.

Top module: `blk_sec_gate`

## Requirements
- R1: The block number is the address shifted right by log2(BLK_BYTES). Block n is bit n of `tbl_flat`, so table word n/32 occupies bits [32w+31:32w] and the block's bit within that word is n%32.
- R2: A table bit of 1 admits only non-secure requests. A table bit of 0 admits only secure requests. Every other valid request is blocked.
- R3: A request with `req_unspec`=1 is treated as secure whatever `req_ns` says.
- R4: A passing request appears on `dn_valid`/`dn_addr`/`dn_write`/`dn_wdata` in the same cycle, unchanged. In that cycle `up_rdata` and `up_err` carry `dn_rdata` and `dn_err`.
- R5: A blocked or idle cycle leaves `dn_valid` at 0.
- R6: A blocked request gives `up_err`=1 when `cfg_err_resp`=1. Otherwise it gives `up_err`=0 and `up_rdata`=0.
- R7: A blocked request while `flt_pend`=0 has an effect at the next clock edge. It sets `flt_pend`, loads `flt_addr` with the request address, and loads `flt_info` with master ID in [15:0], the effective non-secure flag (0 when unspecified) in [16], the block's table bit in [17], and zero in [31:18].
- R8: While `flt_pend`=1 and `flt_clear`=0, more blocked requests are still blocked but leave `flt_pend`, `flt_addr` and `flt_info` unchanged.
- R9: `flt_clear`=1 drops `flt_pend` at the next edge. A blocked request in the same cycle as the clear is captured as a new first fault instead.
- R10: Synchronous active-low reset clears `flt_pend`, `flt_addr` and `flt_info` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_flat | input | NUM_BLKS | Per-block security bits, block n at bit n |
| cfg_err_resp | input | 1 | 1: blocked requests return a bus error |
| flt_clear | input | 1 | Clears the pending fault record |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Request address within the protected range |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | DATA_W | Write data |
| req_ns | input | 1 | Request is non-secure |
| req_unspec | input | 1 | Security attribute unspecified |
| req_master | input | 16 | Requesting master ID |
| dn_valid | output | 1 | Forwarded request valid |
| dn_addr | output | ADDR_W | Forwarded address |
| dn_write | output | 1 | Forwarded direction |
| dn_wdata | output | DATA_W | Forwarded write data |
| dn_rdata | input | DATA_W | Downstream read data |
| dn_err | input | 1 | Downstream error |
| up_rdata | output | DATA_W | Read data returned to the requester |
| up_err | output | 1 | Error returned to the requester |
| flt_pend | output | 1 | A fault is recorded |
| flt_addr | output | ADDR_W | Address of the recorded fault |
| flt_info | output | 32 | Master ID, world and table bit of the recorded fault |

## Verification
The bench targets the edges of the table. It uses block 0, the last block (0xFF, bit 31 of the top word), and neighbouring blocks 0xFE and 0xFF with opposite bits. A mistake in word or bit selection would send one of them to the wrong world. It sends unspecified requests with the non-secure flag raised, which a design that ignored the flag would admit into non-secure blocks. It fires repeated violations while a fault is pending, which a design that captured every violation would record by overwriting the first fault. It also clears the record in the same cycle as a fresh violation, which a design that gave the clear priority would lose.

// File: rtl/blk_sec_pkg.sv
// Shared constants and helpers for the secure/non-secure block access gate.
// Assumes a 16-bit master ID and a 32-bit fault information word.
package blk_sec_pkg;

    localparam int MASTER_W = 16;
    localparam int INFO_W   = 32;
    localparam int WORD_W   = 32;

    // Fields held in the fault information word
    typedef struct packed {
        logic                tbl_bit;
        logic                eff_ns;
        logic [MASTER_W-1:0] master;
    } flt_fields_t;

    // Pack the fault fields into the 32-bit information word, upper bits zero
    function automatic logic [INFO_W-1:0] pack_info(input flt_fields_t f);
        return {{(INFO_W-MASTER_W-2){1'b0}}, f.tbl_bit, f.eff_ns, f.master};
    endfunction

endpackage

// File: rtl/blk_sec_lookup.sv
// Table lookup: picks the security bit of one block out of the flat table.
// The table is grouped into 32-bit words. The upper block-number bits choose
// the word and the low five bits choose the bit within it.
// Assumes at least 32 blocks (BLK_W >= 5).
module blk_sec_lookup
    import blk_sec_pkg::*;
#(
    parameter int BLK_W = 8
) (
    input  logic [BLK_W-1:0]          blk_num,
    input  logic [(1 << BLK_W)-1:0]   tbl_flat,
    output logic                      tbl_bit
);

    localparam int NUM_BLKS  = 1 << BLK_W;
    localparam int NUM_WORDS = NUM_BLKS / WORD_W;
    localparam int WIDX_W    = (BLK_W > 5) ? BLK_W - 5 : 1;

    logic [WORD_W-1:0] words [NUM_WORDS];
    logic [WIDX_W-1:0] word_idx;
    logic [4:0]        bit_idx;

    // Split the flat table into 32-bit words
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        assign words[w] = tbl_flat[w*WORD_W +: WORD_W];
    end

    // Word index: block number divided by 32
    if (BLK_W > 5) begin : g_multi
        assign word_idx = blk_num[BLK_W-1:5];
    end else begin : g_single
        assign word_idx = '0;
    end

    // Bit index: block number modulo 32
    assign bit_idx = blk_num[4:0];

    // Final select of the block's security bit
    always_comb begin
        tbl_bit = words[word_idx][bit_idx];
    end

endmodule

// File: rtl/blk_sec_route.sv
// Admission decision and response steering. All combinational.
// A request passes only when its effective world matches the block's bit:
// bit 1 admits non-secure, bit 0 admits secure. An unspecified attribute
// counts as secure. Passing requests go downstream unchanged. Blocked ones
// are answered here with either a bus error or read-as-zero/write-ignored.
module blk_sec_route #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_ns,
    input  logic              req_unspec,
    input  logic              tbl_bit,
    input  logic              cfg_err_resp,
    input  logic [DATA_W-1:0] dn_rdata,
    input  logic              dn_err,
    output logic              dn_valid,
    output logic [ADDR_W-1:0] dn_addr,
    output logic              dn_write,
    output logic [DATA_W-1:0] dn_wdata,
    output logic [DATA_W-1:0] up_rdata,
    output logic              up_err,
    output logic              blocked,
    output logic              eff_ns
);

    logic admit;

    // Effective world: an unspecified attribute is treated as secure
    always_comb begin
        eff_ns = req_ns & ~req_unspec;
    end

    // Admission: the world must equal the block's table bit
    always_comb begin
        admit   = req_valid & (eff_ns == tbl_bit);
        blocked = req_valid & ~admit;
    end

    // Downstream forwarding: fields pass through, valid only when admitted
    always_comb begin
        dn_valid = admit;
        dn_addr  = req_addr;
        dn_write = req_write;
        dn_wdata = req_wdata;
    end

    // Upstream response: downstream result, or the local blocked response
    always_comb begin
        if (admit) begin
            up_rdata = dn_rdata;
            up_err   = dn_err;
        end else begin
            up_rdata = '0;
            up_err   = blocked & cfg_err_resp;
        end
    end

endmodule

// File: rtl/blk_sec_fault.sv
// Fault capture register. Records address and information for the first
// blocked request and holds them until software clears the record. A
// blocked request in the same cycle as a clear is taken as a new first fault.
// Synchronous active-low reset.
module blk_sec_fault
    import blk_sec_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                blocked,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                eff_ns,
    input  logic                tbl_bit,
    input  logic [MASTER_W-1:0] req_master,
    input  logic                flt_clear,
    output logic                flt_pend,
    output logic [ADDR_W-1:0]   flt_addr,
    output logic [INFO_W-1:0]   flt_info
);

    flt_fields_t fields;
    logic        capture;

    // Gather the fields of the current request
    always_comb begin
        fields.tbl_bit = tbl_bit;
        fields.eff_ns  = eff_ns;
        fields.master  = req_master;
    end

    // Capture when blocked and no fault is held, or one is being cleared
    always_comb begin
        capture = blocked & (~flt_pend | flt_clear);
    end

    // Pending flag and fault record registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_pend <= 1'b0;
            flt_addr <= '0;
            flt_info <= '0;
        end else if (capture) begin
            flt_pend <= 1'b1;
            flt_addr <= req_addr;
            flt_info <= pack_info(fields);
        end else if (flt_clear) begin
            flt_pend <= 1'b0;
        end
    end

endmodule

// File: rtl/blk_sec_gate.sv
// Top of the secure/non-secure block access gate. It looks up the block's
// security bit, decides pass or block in the same cycle, and records the
// first blocked request. Assumes BLK_BYTES is a power of two of at least 32
// and the range 2**ADDR_W holds at least 32 blocks.
module blk_sec_gate
    import blk_sec_pkg::*;
#(
    parameter  int ADDR_W    = 16,
    parameter  int DATA_W    = 32,
    parameter  int BLK_BYTES = 256,
    localparam int BLK_SHIFT = $clog2(BLK_BYTES),
    localparam int BLK_W     = ADDR_W - BLK_SHIFT,
    localparam int NUM_BLKS  = 1 << BLK_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_BLKS-1:0] tbl_flat,
    input  logic                cfg_err_resp,
    input  logic                flt_clear,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_write,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic                req_ns,
    input  logic                req_unspec,
    input  logic [15:0]         req_master,
    output logic                dn_valid,
    output logic [ADDR_W-1:0]   dn_addr,
    output logic                dn_write,
    output logic [DATA_W-1:0]   dn_wdata,
    input  logic [DATA_W-1:0]   dn_rdata,
    input  logic                dn_err,
    output logic [DATA_W-1:0]   up_rdata,
    output logic                up_err,
    output logic                flt_pend,
    output logic [ADDR_W-1:0]   flt_addr,
    output logic [31:0]         flt_info
);

    logic [BLK_W-1:0] blk_num;
    logic             tbl_bit;
    logic             blocked;
    logic             eff_ns;

    // Block number: address divided by the block size
    always_comb begin
        blk_num = req_addr[ADDR_W-1:BLK_SHIFT];
    end

    blk_sec_lookup #(
        .BLK_W (BLK_W)
    ) u_lookup (
        .blk_num  (blk_num),
        .tbl_flat (tbl_flat),
        .tbl_bit  (tbl_bit)
    );

    blk_sec_route #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_route (
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_write    (req_write),
        .req_wdata    (req_wdata),
        .req_ns       (req_ns),
        .req_unspec   (req_unspec),
        .tbl_bit      (tbl_bit),
        .cfg_err_resp (cfg_err_resp),
        .dn_rdata     (dn_rdata),
        .dn_err       (dn_err),
        .dn_valid     (dn_valid),
        .dn_addr      (dn_addr),
        .dn_write     (dn_write),
        .dn_wdata     (dn_wdata),
        .up_rdata     (up_rdata),
        .up_err       (up_err),
        .blocked      (blocked),
        .eff_ns       (eff_ns)
    );

    blk_sec_fault #(
        .ADDR_W (ADDR_W)
    ) u_fault (
        .clk        (clk),
        .rst_n      (rst_n),
        .blocked    (blocked),
        .req_addr   (req_addr),
        .eff_ns     (eff_ns),
        .tbl_bit    (tbl_bit),
        .req_master (req_master),
        .flt_clear  (flt_clear),
        .flt_pend   (flt_pend),
        .flt_addr   (flt_addr),
        .flt_info   (flt_info)
    );

endmodule

// File: rtl/blk_sec_gate_chk.sv
// Assertion checker for blk_sec_gate, attached with a bind statement.
// Looks only at the top module's ports.
module blk_sec_gate_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              cfg_err_resp,
    input logic              flt_clear,
    input logic              dn_valid,
    input logic              dn_err,
    input logic [DATA_W-1:0] up_rdata,
    input logic              up_err,
    input logic              flt_pend,
    input logic [ADDR_W-1:0] flt_addr,
    input logic [31:0]       flt_info
);

    // R5: nothing is forwarded without a request
    a_r5_no_fwd_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !dn_valid);

    // R4: a forwarded request returns the downstream error status
    a_r4_err_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> (up_err == dn_err));

    // R6: blocked with error response off gives zero data and no error
    a_r6_raz: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !dn_valid && !cfg_err_resp) |-> (!up_err && up_rdata == '0));

    // R6: blocked with error response on gives a bus error
    a_r6_bus_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !dn_valid && cfg_err_resp) |-> up_err);

    // R7: a blocked request leaves a pending fault at the next edge
    a_r7_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !dn_valid) |=> flt_pend);

    // R8: a pending record is frozen until cleared
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_pend && !flt_clear) |=> (flt_pend && $stable(flt_addr) && $stable(flt_info)));

    // R9: a clear without a new violation drops the pending flag
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_clear && !(req_valid && !dn_valid)) |=> !flt_pend);

endmodule

bind blk_sec_gate blk_sec_gate_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .cfg_err_resp (cfg_err_resp),
    .flt_clear    (flt_clear),
    .dn_valid     (dn_valid),
    .dn_err       (dn_err),
    .up_rdata     (up_rdata),
    .up_err       (up_err),
    .flt_pend     (flt_pend),
    .flt_addr     (flt_addr),
    .flt_info     (flt_info)
);

// File: tb/blk_sec_gate_tb.sv
// Scoreboard bench. The driver task applies one request per cycle, computes
// the expected response and fault state from the requirements, and pushes
// them into a queue. The monitor pops each item and compares it with the
// outputs in the same cycle.
module blk_sec_gate_tb;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int NBLK   = 256;

    typedef struct {
        string       tag;
        logic        fwd;
        logic        err;
        logic [31:0] rdata;
        logic [15:0] addr;
        logic        wr;
        logic [31:0] wdata;
        logic        pend;
        logic [15:0] faddr;
        logic [31:0] finfo;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NBLK-1:0]   tbl_flat = '0;
    logic              cfg_err_resp = 1'b0;
    logic              flt_clear = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_write = 1'b0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              req_ns = 1'b0;
    logic              req_unspec = 1'b0;
    logic [15:0]       req_master = '0;
    logic              dn_valid;
    logic [ADDR_W-1:0] dn_addr;
    logic              dn_write;
    logic [DATA_W-1:0] dn_wdata;
    logic [DATA_W-1:0] dn_rdata;
    logic              dn_err = 1'b0;
    logic [DATA_W-1:0] up_rdata;
    logic              up_err;
    logic              flt_pend;
    logic [ADDR_W-1:0] flt_addr;
    logic [31:0]       flt_info;

    int   checks = 0;
    int   errors = 0;
    exp_t sbq[$];
    logic m_pend = 1'b0;
    logic [15:0] m_addr = '0;
    logic [31:0] m_info = '0;

    // 50 MHz clock
    always #10 clk = ~clk;

    // Downstream memory model: data depends on the address
    assign dn_rdata = {16'hC0DE, dn_addr};

    blk_sec_gate #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .BLK_BYTES (256)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .tbl_flat (tbl_flat),
        .cfg_err_resp (cfg_err_resp), .flt_clear (flt_clear),
        .req_valid (req_valid), .req_addr (req_addr), .req_write (req_write),
        .req_wdata (req_wdata), .req_ns (req_ns), .req_unspec (req_unspec),
        .req_master (req_master), .dn_valid (dn_valid), .dn_addr (dn_addr),
        .dn_write (dn_write), .dn_wdata (dn_wdata), .dn_rdata (dn_rdata),
        .dn_err (dn_err), .up_rdata (up_rdata), .up_err (up_err),
        .flt_pend (flt_pend), .flt_addr (flt_addr), .flt_info (flt_info)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and push its expectation
    task automatic send(string tag, logic v, logic [15:0] a, logic wr, logic [31:0] wd,
                        logic ns, logic un, logic [15:0] m, logic cfg, logic clr, logic derr);
        exp_t e;
        logic eff, tb_bit, blk;
        @(negedge clk);
        #1;
        req_valid = v; req_addr = a; req_write = wr; req_wdata = wd;
        req_ns = ns; req_unspec = un; req_master = m;
        cfg_err_resp = cfg; flt_clear = clr; dn_err = derr;
        eff    = ns & ~un;
        tb_bit = tbl_flat[a[15:8]];
        blk    = v && (eff != tb_bit);
        e.tag   = tag;
        e.fwd   = v && !blk;
        e.err   = e.fwd ? derr : (blk & cfg);
        e.rdata = e.fwd ? {16'hC0DE, a} : 32'h0;
        e.addr  = a; e.wr = wr; e.wdata = wd;
        e.pend  = m_pend; e.faddr = m_addr; e.finfo = m_info;
        sbq.push_back(e);
        if (blk && (!m_pend || clr)) begin
            m_pend = 1'b1; m_addr = a; m_info = {14'h0, tb_bit, eff, m};
        end else if (clr) begin
            m_pend = 1'b0;
        end
    endtask

    // Monitor: compare outputs mid-cycle against the queued expectation
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                chk(e.tag, "dn_valid", {31'h0, dn_valid}, {31'h0, e.fwd});
                chk(e.tag, "up_err", {31'h0, up_err}, {31'h0, e.err});
                chk(e.tag, "up_rdata", up_rdata, e.rdata);
                if (e.fwd) begin
                    chk(e.tag, "dn_addr", {16'h0, dn_addr}, {16'h0, e.addr});
                    chk(e.tag, "dn_write", {31'h0, dn_write}, {31'h0, e.wr});
                    chk(e.tag, "dn_wdata", dn_wdata, e.wdata);
                end
                chk(e.tag, "flt_pend", {31'h0, flt_pend}, {31'h0, e.pend});
                chk(e.tag, "flt_addr", {16'h0, flt_addr}, {16'h0, e.faddr});
                chk(e.tag, "flt_info", flt_info, e.finfo);
            end
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Stimulus
    initial begin
        tbl_flat[5]    = 1'b1;
        tbl_flat[8'h21] = 1'b1;
        tbl_flat[8'hFF] = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        send("R10 reset state", 0, 16'h0000, 0, 0, 0, 0, 16'h0, 0, 0, 0);
        send("R2 R4 secure read blk0 passes", 1, 16'h0010, 0, 0, 0, 0, 16'h0001, 0, 0, 0);
        send("R2 R6 ns read blk0 blocked RAZ", 1, 16'h0044, 0, 0, 1, 0, 16'h1234, 0, 0, 0);
        send("R1 R7 ns read blk21 passes, first fault", 1, 16'h2100, 0, 0, 1, 0, 16'h0002, 0, 0, 0);
        send("R6 R8 secure write blk21 bus error", 1, 16'h2108, 1, 32'h11223344, 0, 0, 16'h5555, 1, 0, 0);
        send("R3 R8 unspec ns blk21 blocked", 1, 16'h21F0, 0, 0, 1, 1, 16'h6666, 1, 0, 0);
        send("R3 R4 unspec ns blk0 passes dn_err", 1, 16'h0080, 0, 0, 1, 1, 16'h0003, 0, 0, 1);
        send("R9 clear idle", 0, 16'h0000, 0, 0, 0, 0, 16'h0, 0, 1, 0);
        send("R9 R1 secure read blkFF blocked", 1, 16'hFF10, 0, 0, 0, 0, 16'hBEEF, 0, 0, 0);
        send("R9 clear with new violation", 1, 16'h0300, 0, 0, 1, 0, 16'h0A0A, 0, 1, 0);
        send("R1 R4 R5 ns write blk5 passes", 1, 16'h0504, 1, 32'hCAFEF00D, 1, 0, 16'h0004, 0, 0, 0);
        send("R1 ns last address blkFF passes", 1, 16'hFFFF, 0, 0, 1, 0, 16'h0005, 0, 0, 0);
        send("R1 R5 ns write blkFE blocked", 1, 16'hFE00, 1, 32'hDEADBEEF, 1, 0, 16'h0007, 0, 0, 0);
        send("R8 hold after violation", 0, 16'h0000, 0, 0, 0, 0, 16'h0, 0, 0, 0);
        send("R9 final clear", 0, 16'h0000, 0, 0, 0, 0, 16'h0, 0, 1, 0);
        send("R9 cleared state", 0, 16'h0000, 0, 0, 0, 0, 16'h0, 0, 0, 0);
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule